// File: doc/BRIEF.md
# Arrival-Order Bus Arbiter

A central arbiter that shares one bus among several masters and hands it out strictly in the order the requests came in. Every master has one request input and one grant output to the arbiter. When a master raises its request it is added to the back of an internal waiting line, and the master at the front of that line holds the grant. The holder keeps the bus for as long as its request stays high. The arbiter never takes the bus away. A master that never lets go therefore stalls every other master.

When the holder lowers its request, it leaves the line and the grant passes to the next master in line. Masters that raise their requests on the same clock edge join the line lowest index first. A master that waits must keep its request high until it is granted. The line has one slot per master, so it cannot overflow.

Top module: `fifo_bus_arbiter`

## Requirements
- R1: After reset, a request raised while no master is queued is granted on the first clock edge that samples it. The grant is a combinational decode of registered state, so it is visible directly after that edge.
- R2: Masters are granted in the order in which their requests were first sampled high.
- R3: Requests first sampled on the same edge are queued in ascending master index, so index 0 is served before index 1, and so on.
- R4: While the granted master keeps its request high, its grant stays asserted. No other master is granted, however long the holder keeps the bus.
- R5: When the granted master's request is sampled low, its grant drops on that edge. On the same edge the grant moves to the next queued master, if there is one.
- R6: A master that is queued or holding the bus is not queued again while its request stays high, so it receives exactly one grant period per request.
- R7: At most one grant output is high at any time. No grant is high while the queue is empty.
- R8: The queue holds one entry per master, and its occupancy never exceeds the number of masters.
- R9: While reset is high, and directly after it, all grants are low and the queue is empty.
- R10: A master that lowers its request after being granted and then raises it again is placed at the tail, behind the masters already waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | N_MASTERS | Request line per master, bit i belongs to master i |
| gnt_o | output | N_MASTERS | Grant line per master, one-hot or zero |

## Verification
The bench puts all masters in line on a single edge and expects the grants in ascending index order. A design that breaks ties another way, or that grants two masters at once, fails there. It raises requests out of index order on separate cycles and expects service in arrival order; a fixed-priority design would hand the bus to the lower index first. In one test a master keeps its request high for many cycles while it waits. If that master had been queued on every cycle, it would be granted again after it releases the bus. Another test holds a grant for many cycles to confirm that nothing preempts it. A released master that requests again must go to the back of the line, not the front.

// File: rtl/fifo_arb_pkg.sv
package fifo_arb_pkg;

    // Widest master index the head descriptor can carry.
    localparam int HEAD_IDX_W = 8;

    // Descriptor of the current queue head, passed from storage to grant decode.
    typedef struct packed {
        logic                  valid;
        logic [HEAD_IDX_W-1:0] idx;
    } head_info_t;

    // Bits needed to index n entries (at least one).
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/arb_arrival_detect.sv
module arb_arrival_detect #(
    parameter int N_MASTERS = 4
) (
    input  logic [N_MASTERS-1:0] req_i,
    input  logic [N_MASTERS-1:0] queued_i,
    output logic [N_MASTERS-1:0] arrive_o
);
    // A request counts as a new arrival only if that master is not already in line.
    always_comb begin
        arrive_o = req_i & ~queued_i;
    end
endmodule

// File: rtl/arb_order_queue.sv
module arb_order_queue
    import fifo_arb_pkg::*;
#(
    parameter int N_MASTERS = 4,
    parameter int IDX_W     = 2,
    parameter int CNT_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_MASTERS-1:0] req_i,
    input  logic [N_MASTERS-1:0] arrive_i,
    output logic [N_MASTERS-1:0] queued_o,
    output logic [CNT_W-1:0]     count_o,
    output head_info_t           head_o
);
    logic [IDX_W-1:0]     slots     [N_MASTERS];
    logic [IDX_W-1:0]     nxt_slots [N_MASTERS];
    logic [CNT_W-1:0]     cnt, nxt_cnt;
    logic [N_MASTERS-1:0] mask, nxt_mask;
    logic                 release_head;

    always_comb begin
        nxt_slots    = slots;
        nxt_cnt      = cnt;
        nxt_mask     = mask;
        release_head = (cnt != '0) && !req_i[slots[0]];
        // The head leaves when its request is sampled low: shift the line forward.
        if (release_head) begin
            for (int k = 0; k < N_MASTERS - 1; k++) begin
                nxt_slots[k] = slots[k+1];
            end
            nxt_slots[N_MASTERS-1] = '0;
            nxt_cnt                = cnt - 1'b1;
            nxt_mask[slots[0]]     = 1'b0;
        end
        // New arrivals go to the tail, lowest index first.
        for (int i = 0; i < N_MASTERS; i++) begin
            if (arrive_i[i]) begin
                nxt_slots[nxt_cnt[IDX_W-1:0]] = IDX_W'(i);
                nxt_cnt                       = nxt_cnt + 1'b1;
                nxt_mask[i]                   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N_MASTERS; k++) begin
                slots[k] <= '0;
            end
            cnt  <= '0;
            mask <= '0;
        end else begin
            slots <= nxt_slots;
            cnt   <= nxt_cnt;
            mask  <= nxt_mask;
        end
    end

    always_comb begin
        queued_o     = mask;
        count_o      = cnt;
        head_o.valid = (cnt != '0);
        head_o.idx   = HEAD_IDX_W'(slots[0]);
    end
endmodule

// File: rtl/arb_grant_decode.sv
module arb_grant_decode
    import fifo_arb_pkg::*;
#(
    parameter int N_MASTERS = 4
) (
    input  head_info_t           head_i,
    output logic [N_MASTERS-1:0] gnt_o
);
    for (genvar g = 0; g < N_MASTERS; g++) begin : g_dec
        assign gnt_o[g] = head_i.valid && (head_i.idx == HEAD_IDX_W'(g));
    end
endmodule

// File: rtl/fifo_bus_arbiter.sv
module fifo_bus_arbiter
    import fifo_arb_pkg::*;
#(
    parameter int N_MASTERS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_MASTERS-1:0] req_i,
    output logic [N_MASTERS-1:0] gnt_o
);
    localparam int IDX_W = idx_bits(N_MASTERS);
    localparam int CNT_W = $clog2(N_MASTERS + 1);

    logic [N_MASTERS-1:0] arrive;
    logic [N_MASTERS-1:0] queued;
    logic [CNT_W-1:0]     occupancy;
    head_info_t           head;

    arb_arrival_detect #(.N_MASTERS(N_MASTERS)) u_arrive (
        .req_i    (req_i),
        .queued_i (queued),
        .arrive_o (arrive)
    );

    arb_order_queue #(
        .N_MASTERS (N_MASTERS),
        .IDX_W     (IDX_W),
        .CNT_W     (CNT_W)
    ) u_queue (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req_i),
        .arrive_i (arrive),
        .queued_o (queued),
        .count_o  (occupancy),
        .head_o   (head)
    );

    arb_grant_decode #(.N_MASTERS(N_MASTERS)) u_dec (
        .head_i (head),
        .gnt_o  (gnt_o)
    );
endmodule

// File: rtl/fifo_arb_checker.sv
module fifo_arb_checker #(
    parameter int N_MASTERS = 4,
    parameter int CNT_W     = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic [N_MASTERS-1:0] req_i,
    input logic [N_MASTERS-1:0] gnt_o,
    input logic [CNT_W-1:0]     q_count
);
    assert_single_grant_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_o));

    assert_idle_no_grant_R7: assert property (@(posedge clk) disable iff (rst)
        (q_count == '0) |-> (gnt_o == '0));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        q_count <= CNT_W'(N_MASTERS));

    assert_idle_request_granted_R1: assert property (@(posedge clk) disable iff (rst)
        (q_count == '0 && req_i != '0) |=> (gnt_o != '0));

    for (genvar g = 0; g < N_MASTERS; g++) begin : g_m
        assert_hold_no_preempt_R4: assert property (@(posedge clk) disable iff (rst)
            (gnt_o[g] && req_i[g]) |=> gnt_o[g]);

        assert_release_drops_R5: assert property (@(posedge clk) disable iff (rst)
            (gnt_o[g] && !req_i[g]) |=> !gnt_o[g]);
    end
endmodule

bind fifo_bus_arbiter fifo_arb_checker #(
    .N_MASTERS (N_MASTERS),
    .CNT_W     (CNT_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req_i),
    .gnt_o   (gnt_o),
    .q_count (occupancy)
);

// File: tb/tb_fifo_bus_arbiter.sv
`timescale 1ns/1ps
module tb_fifo_bus_arbiter;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req_r = '0;
    logic [N-1:0] gnt;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference line: arrival order kept by the bench.
    int mq [N];
    int mcnt;
    bit mmask [N];

    fifo_bus_arbiter #(.N_MASTERS(N)) dut (
        .clk   (clk),
        .rst   (rst),
        .req_i (req_r),
        .gnt_o (gnt)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            mcnt = 0;
            for (int i = 0; i < N; i++) begin
                mq[i] = 0; mmask[i] = 0;
            end
        end else begin
            if (mcnt > 0 && !req_r[mq[0]]) begin
                mmask[mq[0]] = 0;
                for (int k = 0; k < N - 1; k++) mq[k] = mq[k+1];
                mcnt = mcnt - 1;
            end
            for (int i = 0; i < N; i++) begin
                if (req_r[i] && !mmask[i]) begin
                    mq[mcnt] = i; mcnt = mcnt + 1; mmask[i] = 1;
                end
            end
        end
    end

    function automatic logic [N-1:0] model_grant();
        logic [N-1:0] v = '0;
        if (mcnt > 0) v[mq[0]] = 1'b1;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: gnt actual=%b expected=%b at %0t", tag, got, exp, $time);
        end
    endtask

    // Drive at a falling edge, then sample one cycle later at the next falling edge.
    task automatic drive(input logic [N-1:0] r);
        req_r = r;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R9 in reset", gnt, 4'b0000);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 after reset", gnt, 4'b0000);

        // Same-edge arrivals, ascending index service.
        drive(4'b1111); chk("R1 R3 first of tie", gnt, 4'b0001);
        drive(4'b1110); chk("R3 R5 second", gnt, 4'b0010);
        drive(4'b1100); chk("R3 third", gnt, 4'b0100);
        drive(4'b1000); chk("R3 fourth", gnt, 4'b1000);
        drive(4'b0000); chk("R7 empty", gnt, 4'b0000);

        // Arrival order beats index order.
        drive(4'b0100); chk("R1 idle grant", gnt, 4'b0100);
        drive(4'b0110); chk("R4 holder kept", gnt, 4'b0100);
        drive(4'b1110); chk("R4 holder kept 2", gnt, 4'b0100);
        drive(4'b1010); chk("R2 earlier arrival first", gnt, 4'b0010);
        drive(4'b1000); chk("R2 last arrival", gnt, 4'b1000);
        drive(4'b0000); chk("R5 release to empty", gnt, 4'b0000);

        // Hog, single entry per request, re-request to tail.
        drive(4'b0001); chk("R1 idle grant m0", gnt, 4'b0001);
        for (int c = 0; c < 12; c++) begin
            drive(4'b0011); chk("R4 hog not preempted", gnt, 4'b0001);
        end
        drive(4'b0010); chk("R5 handover", gnt, 4'b0010);
        drive(4'b0011); chk("R10 requeue waits", gnt, 4'b0010);
        drive(4'b0001); chk("R10 requeued at tail", gnt, 4'b0001);
        drive(4'b0000); chk("R6 no duplicate entry", gnt, 4'b0000);

        // Random traffic against the reference line.
        for (int c = 0; c < 4000; c++) begin
            logic [N-1:0] r = req_r;
            for (int i = 0; i < N; i++) begin
                if (!r[i]) begin
                    if ($urandom_range(3) == 0) r[i] = 1'b1;
                end else if (gnt[i]) begin
                    if ($urandom_range(4) == 0) r[i] = 1'b0;
                end
            end
            drive(r);
            chk("R2 random order", gnt, model_grant());
            checks++;
            if ($countones(gnt) > 1) begin
                errors++;
                $display("FAIL R7: gnt actual=%b expected=at most one bit", gnt);
            end
        end
        drive(4'b0000);
        drive(4'b0000);
        repeat (N) drive(4'b0000);
        chk("R7 drained", gnt, 4'b0000);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule